// File: doc/BRIEF.md
# Edge/Level Interrupt Capture and Dispatch

This block collects a parameterised set of interrupt request inputs (64 by default) and drives a bank of output lines. Each input can be set to edge or level mode. For each source the block holds four bits: a pending bit, an in-service bit, a last-level bit and an edge-mode bit. It also applies a per-source mask. Each source also has a vector entry that names the output line it drives. When a source is serviced, the block raises or lowers the line that its vector entry names.

The block takes already-decoded register strobes from a surrounding register interface. These are a full mask write, a full edge-mode write, a write-one-to-clear, and a single vector-table entry write. A mask change is replayed as an assert event for bits that become unmasked and a deassert event for bits that become masked. The block also provides a masked status view. It handles one event per clock. A register strobe takes the cycle ahead of input changes. Changed inputs are handled one per cycle, lowest index first.

Top module: `irq_capture`

## Requirements
- R1: In edge mode (edge bit = 1), an input sampled high while its last-level bit is 0 sets pending. If the source is unmasked, the same cycle's update also sets in-service and raises the output line whose index equals the source's vector entry. The line is visible one clock after the input is sampled high.
- R2: In edge mode, the input going low clears only the last-level bit. Pending, in-service, status and the output line keep their values.
- R3: In level mode (edge bit = 0), pending follows the input. An unmasked rise sets in-service and raises the vector line. A fall of an in-service source clears in-service and lowers its vector line.
- R4: After reset the mask is all ones (bit = 1 means masked), and every source is in level mode with vector entry 0. Pending, in-service, last-level, status and all output lines are 0. While masked, a pending source produces no line and no status.
- R5: A mask write that clears mask bits selects, among those sources, the ones that are pending. Only the lowest-numbered of them gets in-service and has its vector line raised. The rest stay pending without service.
- R6: A mask write that sets mask bits lowers a line only for a source that is in service and no longer pending. A source that is still pending keeps its line high.
- R7: A clear write acts only on bits whose source is in edge mode. For those bits it clears pending and in-service. Of them, only the lowest-numbered source that was in service has its vector line lowered. Bits of level-mode sources have no effect.
- R8: Status equals in-service AND NOT mask, bit by bit.
- R9: A vector entry of NUM_LINE or more changes no output line. The source's pending and in-service bookkeeping proceeds as usual.
- R10: When several inputs change in one cycle, they are processed one per clock in ascending index order. At most one output line rises and at most one falls per clock.
- R11: A register strobe takes priority over an input event in the same cycle, and the input event is handled in the next cycle. Between strobes the priority is mask, then clear, then edge mode, then vector write.
- R12: A vector-table write moves no output line. The new entry applies to events handled after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC | Interrupt request inputs |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | NUM_SRC | New mask value (1 = masked) |
| clrWrEn | input | 1 | Write-one-to-clear strobe |
| clrWrData | input | NUM_SRC | Bits to clear |
| edgeWrEn | input | 1 | Edge-mode register write strobe |
| edgeWrData | input | NUM_SRC | New edge-mode value (1 = edge) |
| vecWrEn | input | 1 | Vector entry write strobe |
| vecWrIdx | input | $clog2(NUM_SRC) | Source whose vector entry is written |
| vecWrData | input | VEC_W | New vector entry |
| lineOut | output | NUM_LINE | Output lines |
| status | output | NUM_SRC | In-service AND NOT mask |

## Verification
An input change and a register strobe can arrive in the same cycle. The bench provokes this by driving a new edge-mode input and a clear write on the same clock. The clear names only a level-mode bit. The bench then expects the outputs to stay unchanged for one cycle, while the strobe is handled, and the new source's line to appear one cycle later. A second overlap is a multi-source rise. The bench judges it by the one-line-per-cycle sequence in ascending order on the lines and the status.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SRC,
    OP_MASK,
    OP_CLR,
    OP_EDGE,
    OP_VEC
  } irqOp_e;

  // Strobe bundle from control to datapath
  typedef struct packed {
    irqOp_e op;
    logic   srcLvl;
  } irqStrb_t;

endpackage

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vecIn,
  output logic [IW-1:0] idx,
  output logic          found
);

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vecIn[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_capture_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               maskWrEn,
  input  logic               clrWrEn,
  input  logic               edgeWrEn,
  input  logic               vecWrEn,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] lastLvl,
  output irqStrb_t           strb,
  output logic [IDX_W-1:0]   srcIdx
);

  logic [NUM_SRC-1:0] changed;
  logic               chgFound;

  assign changed = irqIn ^ lastLvl;

  irq_lowest #(.N(NUM_SRC)) uChgPick (
    .vecIn(changed),
    .idx  (srcIdx),
    .found(chgFound)
  );

  // Register strobes win the cycle; input changes wait
  always_comb begin
    strb.srcLvl = irqIn[srcIdx];
    if (maskWrEn)      strb.op = OP_MASK;
    else if (clrWrEn)  strb.op = OP_CLR;
    else if (edgeWrEn) strb.op = OP_EDGE;
    else if (vecWrEn)  strb.op = OP_VEC;
    else if (chgFound) strb.op = OP_SRC;
    else               strb.op = OP_IDLE;
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_capture_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_LINE = 64,
  parameter int VEC_W    = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LINE_W = $clog2(NUM_LINE)
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqStrb_t            strb,
  input  logic [IDX_W-1:0]    srcIdx,
  input  logic [NUM_SRC-1:0]  maskWrData,
  input  logic [NUM_SRC-1:0]  clrWrData,
  input  logic [NUM_SRC-1:0]  edgeWrData,
  input  logic [IDX_W-1:0]    vecWrIdx,
  input  logic [VEC_W-1:0]    vecWrData,
  output logic [NUM_LINE-1:0] lineOut,
  output logic [NUM_SRC-1:0]  status,
  output logic [NUM_SRC-1:0]  lastLvl,
  output logic [NUM_SRC-1:0]  edgeMode
);

  logic [NUM_SRC-1:0]  pend, isr, maskReg;
  logic [NUM_SRC-1:0]  pendN, isrN, lastN, maskN, edgeN;
  logic [NUM_LINE-1:0] lineN;
  logic [VEC_W-1:0]    vecTab [NUM_SRC];

  logic [NUM_SRC-1:0]  assertSet, deassertSet, clrSet;
  logic [IDX_W-1:0]    assertIdx, deassertIdx;
  logic                assertHit, deassertHit;
  logic                raiseEn, lowerEn;
  logic [IDX_W-1:0]    raiseIdx, lowerIdx;
  logic [VEC_W-1:0]    raiseVec, lowerVec;

  assign clrSet      = clrWrData & edgeMode;
  assign assertSet   = maskReg & ~maskWrData & pend;
  assign deassertSet = (strb.op == OP_CLR) ? (clrSet & isr)
                                           : (~maskReg & maskWrData & isr & ~pend);

  irq_lowest #(.N(NUM_SRC)) uAssertPick (
    .vecIn(assertSet),
    .idx  (assertIdx),
    .found(assertHit)
  );

  irq_lowest #(.N(NUM_SRC)) uDeassertPick (
    .vecIn(deassertSet),
    .idx  (deassertIdx),
    .found(deassertHit)
  );

  always_comb begin
    pendN    = pend;
    isrN     = isr;
    lastN    = lastLvl;
    maskN    = maskReg;
    edgeN    = edgeMode;
    raiseEn  = 1'b0;
    lowerEn  = 1'b0;
    raiseIdx = srcIdx;
    lowerIdx = srcIdx;
    unique case (strb.op)
      OP_SRC: begin
        if (edgeMode[srcIdx]) begin
          if (strb.srcLvl && !lastLvl[srcIdx]) pendN[srcIdx] = 1'b1;
        end else begin
          pendN[srcIdx] = strb.srcLvl;
        end
        lastN[srcIdx] = strb.srcLvl;
        if (strb.srcLvl) begin
          if (pendN[srcIdx] && !maskReg[srcIdx]) begin
            isrN[srcIdx] = 1'b1;
            raiseEn      = 1'b1;
          end
        end else if (isr[srcIdx] && !pendN[srcIdx]) begin
          isrN[srcIdx] = 1'b0;
          lowerEn      = 1'b1;
        end
      end
      OP_MASK: begin
        maskN = maskWrData;
        if (assertHit) begin
          isrN[assertIdx] = 1'b1;
          raiseEn         = 1'b1;
          raiseIdx        = assertIdx;
        end
        if (deassertHit) begin
          isrN[deassertIdx] = 1'b0;
          lowerEn           = 1'b1;
          lowerIdx          = deassertIdx;
        end
      end
      OP_CLR: begin
        pendN = pend & ~clrSet;
        isrN  = isr & ~clrSet;
        if (deassertHit) begin
          lowerEn  = 1'b1;
          lowerIdx = deassertIdx;
        end
      end
      OP_EDGE: edgeN = edgeWrData;
      default: ;
    endcase
  end

  assign raiseVec = vecTab[raiseIdx];
  assign lowerVec = vecTab[lowerIdx];

  // Raise first, then lower, so a lower on the same line wins
  always_comb begin
    lineN = lineOut;
    if (raiseEn && (int'(raiseVec) < NUM_LINE)) lineN[raiseVec[LINE_W-1:0]] = 1'b1;
    if (lowerEn && (int'(lowerVec) < NUM_LINE)) lineN[lowerVec[LINE_W-1:0]] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= '0;
      isr      <= '0;
      lastLvl  <= '0;
      maskReg  <= '1;
      edgeMode <= '0;
      lineOut  <= '0;
      for (int i = 0; i < NUM_SRC; i++) vecTab[i] <= '0;
    end else begin
      pend     <= pendN;
      isr      <= isrN;
      lastLvl  <= lastN;
      maskReg  <= maskN;
      edgeMode <= edgeN;
      lineOut  <= lineN;
      if (strb.op == OP_VEC) vecTab[vecWrIdx] <= vecWrData;
    end
  end

  assign status = isr & ~maskReg;

endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_capture_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int NUM_LINE = 64,
  parameter int VEC_W    = 8,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  irqIn,
  input  logic                maskWrEn,
  input  logic [NUM_SRC-1:0]  maskWrData,
  input  logic                clrWrEn,
  input  logic [NUM_SRC-1:0]  clrWrData,
  input  logic                edgeWrEn,
  input  logic [NUM_SRC-1:0]  edgeWrData,
  input  logic                vecWrEn,
  input  logic [IDX_W-1:0]    vecWrIdx,
  input  logic [VEC_W-1:0]    vecWrData,
  output logic [NUM_LINE-1:0] lineOut,
  output logic [NUM_SRC-1:0]  status
);

  irqStrb_t           strb;
  logic [IDX_W-1:0]   srcIdx;
  logic [NUM_SRC-1:0] lastLvl;
  logic [NUM_SRC-1:0] edgeMode;

  irq_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .maskWrEn(maskWrEn),
    .clrWrEn (clrWrEn),
    .edgeWrEn(edgeWrEn),
    .vecWrEn (vecWrEn),
    .irqIn   (irqIn),
    .lastLvl (lastLvl),
    .strb    (strb),
    .srcIdx  (srcIdx)
  );

  irq_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_LINE(NUM_LINE),
    .VEC_W   (VEC_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srcIdx    (srcIdx),
    .maskWrData(maskWrData),
    .clrWrData (clrWrData),
    .edgeWrData(edgeWrData),
    .vecWrIdx  (vecWrIdx),
    .vecWrData (vecWrData),
    .lineOut   (lineOut),
    .status    (status),
    .lastLvl   (lastLvl),
    .edgeMode  (edgeMode)
  );

endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_LINE = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_SRC-1:0]  irqIn,
  input logic                maskWrEn,
  input logic [NUM_SRC-1:0]  maskWrData,
  input logic                clrWrEn,
  input logic [NUM_SRC-1:0]  clrWrData,
  input logic [NUM_SRC-1:0]  lastLvl,
  input logic [NUM_SRC-1:0]  edgeMode,
  input logic [NUM_LINE-1:0] lineOut,
  input logic [NUM_SRC-1:0]  status
);

  // R8: freshly masked bits never show in status
  p_mask_hides_r8: assert property (@(posedge clk) disable iff (!rstN)
    maskWrEn |=> ((status & $past(maskWrData)) == '0));

  // R7: cleared edge-mode bits leave service
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrEn && !maskWrEn) |=> ((status & $past(clrWrData & edgeMode)) == '0));

  // R10: at most one line rises per clock
  p_single_rise_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lineOut & ~$past(lineOut)) <= 1);

  // R10: at most one line falls per clock
  p_single_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~lineOut & $past(lineOut)) <= 1);

  // R12: with no mask/clear strobe and no input change, lines hold
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!maskWrEn && !clrWrEn && (irqIn == lastLvl)) |=> $stable(lineOut));

endmodule

bind irq_capture irq_capture_chk #(.NUM_SRC(NUM_SRC), .NUM_LINE(NUM_LINE)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .maskWrEn  (maskWrEn),
  .maskWrData(maskWrData),
  .clrWrEn   (clrWrEn),
  .clrWrData (clrWrData),
  .lastLvl   (lastLvl),
  .edgeMode  (edgeMode),
  .lineOut   (lineOut),
  .status    (status)
);

// File: tb/sim_irq_capture.sv
module sim_irq_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        maskWrEn = 1'b0;
  logic [63:0] maskWrData = '0;
  logic        clrWrEn = 1'b0;
  logic [63:0] clrWrData = '0;
  logic        edgeWrEn = 1'b0;
  logic [63:0] edgeWrData = '0;
  logic        vecWrEn = 1'b0;
  logic [5:0]  vecWrIdx = '0;
  logic [7:0]  vecWrData = '0;
  logic [63:0] lineOut;
  logic [63:0] status;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic [63:0] line;
    logic [63:0] st;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_capture u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .edgeWrEn(edgeWrEn), .edgeWrData(edgeWrData),
    .vecWrEn(vecWrEn), .vecWrIdx(vecWrIdx), .vecWrData(vecWrData),
    .lineOut(lineOut), .status(status)
  );

  function automatic logic [63:0] b(input int i);
    return 64'd1 << i;
  endfunction

  // Expected outputs after the next rising edge
  task automatic wantNext(input logic [63:0] l, input logic [63:0] s, input string tag);
    exp_t e;
    e.due = cyc + 1; e.line = l; e.st = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic clkStep();
    @(negedge clk);
    maskWrEn = 1'b0; clrWrEn = 1'b0; edgeWrEn = 1'b0; vecWrEn = 1'b0;
  endtask

  // Monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        nChecks++;
        if (lineOut !== e.line || status !== e.st) begin
          nFail++;
          $display("FAIL %s: line=%h status=%h expected line=%h status=%h",
                   e.tag, lineOut, status, e.line, e.st);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    wantNext('0, '0, "R4 reset state");
    clkStep();
    // Vector table: entry i -> line i, entry 3 out of range
    for (int i = 0; i < 64; i++) begin
      vecWrEn = 1'b1; vecWrIdx = 6'(i);
      vecWrData = (i == 3) ? 8'd200 : 8'(i);
      wantNext('0, '0, "R12 vector write quiet");
      clkStep();
    end
    // R4: masked at reset, two level rises
    irqIn[5] = 1'b1; irqIn[7] = 1'b1;
    wantNext('0, '0, "R4 masked src5"); clkStep();
    wantNext('0, '0, "R4 masked src7"); clkStep();
    // R5: unmask all, lowest pending serviced only
    maskWrEn = 1'b1; maskWrData = '0;
    wantNext(b(5), b(5), "R5 unmask lowest"); clkStep();
    // R3: level fall
    irqIn[5] = 1'b0;
    wantNext('0, '0, "R3 level fall"); clkStep();
    irqIn[7] = 1'b0;
    wantNext('0, '0, "R3 level fall unserviced"); clkStep();
    irqIn[7] = 1'b1;
    wantNext(b(7), b(7), "R3 level rise"); clkStep();
    // R6/R8: masking a still-pending source
    maskWrEn = 1'b1; maskWrData = b(7);
    wantNext(b(7), '0, "R6 R8 mask hides status"); clkStep();
    maskWrEn = 1'b1; maskWrData = '0;
    wantNext(b(7), b(7), "R5 unmask replay"); clkStep();
    irqIn[7] = 1'b0;
    wantNext('0, '0, "R3 level fall"); clkStep();
    // Edge mode on 3, 8, 9, 10
    edgeWrEn = 1'b1; edgeWrData = b(3) | b(8) | b(9) | b(10);
    wantNext('0, '0, "R11 edge write"); clkStep();
    irqIn[8] = 1'b1;
    wantNext(b(8), b(8), "R1 edge rise"); clkStep();
    irqIn[8] = 1'b0;
    wantNext(b(8), b(8), "R2 edge fall keeps"); clkStep();
    // R11: input event and clear strobe in the same cycle
    irqIn[9] = 1'b1; clrWrEn = 1'b1; clrWrData = b(5);
    wantNext(b(8), b(8), "R11 R7 strobe first, level bit ignored"); clkStep();
    wantNext(b(8) | b(9), b(8) | b(9), "R11 deferred input event"); clkStep();
    // R7: clear two edge sources, lowest line lowered
    clrWrEn = 1'b1; clrWrData = b(8) | b(9);
    wantNext(b(9), '0, "R7 clear lowers lowest"); clkStep();
    irqIn[9] = 1'b0;
    wantNext(b(9), '0, "R2 edge fall"); clkStep();
    irqIn[9] = 1'b1;
    wantNext(b(9), b(9), "R1 edge re-rise"); clkStep();
    clrWrEn = 1'b1; clrWrData = b(9);
    wantNext('0, '0, "R7 clear releases"); clkStep();
    // R10: simultaneous level changes
    irqIn[12] = 1'b1; irqIn[20] = 1'b1;
    wantNext(b(12), b(12), "R10 first of two"); clkStep();
    wantNext(b(12) | b(20), b(12) | b(20), "R10 second of two"); clkStep();
    irqIn[12] = 1'b0; irqIn[20] = 1'b0;
    wantNext(b(20), b(20), "R10 first fall"); clkStep();
    wantNext('0, '0, "R10 second fall"); clkStep();
    // R9: out-of-range vector
    irqIn[3] = 1'b1;
    wantNext('0, b(3), "R9 no line for vector 200"); clkStep();
    clrWrEn = 1'b1; clrWrData = b(3);
    wantNext('0, '0, "R9 clear out-of-range"); clkStep();
    // R12: vector change applies to later events only
    irqIn[12] = 1'b1;
    wantNext(b(12), b(12), "R3 level rise"); clkStep();
    vecWrEn = 1'b1; vecWrIdx = 6'd12; vecWrData = 8'd30;
    wantNext(b(12), b(12), "R12 write moves nothing"); clkStep();
    irqIn[12] = 1'b0;
    wantNext(b(12), '0, "R12 fall uses new vector"); clkStep();
    vecWrEn = 1'b1; vecWrIdx = 6'd12; vecWrData = 8'd12;
    wantNext(b(12), '0, "R12 restore vector"); clkStep();
    irqIn[12] = 1'b1;
    wantNext(b(12), b(12), "R3 rise"); clkStep();
    irqIn[12] = 1'b0;
    wantNext('0, '0, "R3 fall"); clkStep();
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard: %0d pending, expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule